// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block guards a battery-backed static memory against corruption while its supply is out of tolerance. It runs from the system clock. Its one view of the supply is a single supply-good bit from an external voltage comparator. The block brings that bit into the clock domain and then gates the host's active-low chip-enable and write-enable strobes on their way to the memory. It also produces an enable for an open-drain, active-low reset line. That line can hold a processor in reset while the supply settles.

When the supply fails, the block blocks both memory strobes at once and unconditionally, and it asks for reset. A write that is already under way is cut off at that moment. When the supply comes back, the block first requires the supply-good bit to stay high for a set number of consecutive samples. Two hold intervals then run from the moment the supply is trusted, one for write protection and one for reset. Each releases when its own count expires. If the supply drops during either hold, the whole sequence starts again from the protected state with reset asserted. Every delay is a cycle-count parameter. The defaults are set for a 100 MHz clock: a 125 ms write-protect hold and a 350 ms reset hold.

Top module: `pwr_guard`

## Requirements
- R1: While `rst_n` is low, `mem_ce_n` and `mem_we_n` are 1, `rst_pull_en` is 1 and `wp_active` is 1, whatever the host strobes are.
- R2: When `supply_ok_raw` falls, the outputs change after exactly two rising clock edges (the synchronizer depth). At that point `mem_ce_n` = 1, `mem_we_n` = 1, `rst_pull_en` = 1 and `wp_active` = 1. After one edge the outputs are still unchanged.
- R3: While protection is active, changes on `host_ce_n` and `host_we_n` have no effect: both memory strobes stay at 1.
- R4: A write in progress (`host_ce_n` = 0 and `host_we_n` = 0 held low) at the moment of a failure is cut off. `mem_we_n` and `mem_ce_n` go to 1 on the R2 edge, even though the host strobes stay low.
- R5: The supply is trusted only after `supply_ok_raw` has been sampled high for DEBOUNCE_CYCLES consecutive synchronized samples. Any low sample restarts the count, so every release time is measured from the last rising edge of `supply_ok_raw`.
- R6: Write protection (`wp_active`, together with the strobe gating) releases exactly 2 + DEBOUNCE_CYCLES + WP_HOLD_CYCLES rising edges after `supply_ok_raw` rises and stays high. It is still active one edge earlier.
- R7: `rst_pull_en` releases exactly 2 + DEBOUNCE_CYCLES + RST_HOLD_CYCLES rising edges after `supply_ok_raw` rises and stays high. It is still 1 one edge earlier.
- R8: If the supply drops during either hold interval, protection and reset are forced again after two edges. The next recovery then takes the full R6 and R7 intervals counted from the new rise.
- R9: When protection is inactive, `mem_ce_n` equals `host_ce_n` and `mem_we_n` equals `host_we_n` in the same cycle, with no register delay.
- R10: `rst_pull_en` is a drive-low enable for an open-drain reset line: 1 means pull the line low (reset asserted) and 0 means release it to the external pull-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| supply_ok_raw | input | 1 | Asynchronous supply-good bit from the comparator, 1 = supply above trip point |
| host_ce_n | input | 1 | Host chip-enable, active low |
| host_we_n | input | 1 | Host write-enable, active low |
| mem_ce_n | output | 1 | Gated chip-enable to the memory, active low |
| mem_we_n | output | 1 | Gated write-enable to the memory, active low |
| rst_pull_en | output | 1 | Open-drain reset drive enable, 1 = pull reset low |
| wp_active | output | 1 | 1 while write protection is in force |

## Verification
The hardest situation to reach from the ports is a supply loss in the middle of recovery. This covers a glitch inside the debounce window and a drop after write protection has ended but while reset is still held. The bench shrinks the debounce and hold counts to a few dozen cycles. It drives `supply_ok_raw` on falling clock edges, so each glitch and each drop falls at a known number of edges after the previous rise. It then checks the release edges from the new rise, one edge before release and at the release edge itself.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;

  // A hold interval is open while the elapsed count is below its limit.
  function automatic logic hold_open(input int unsigned elapsed, input int unsigned limit);
    return elapsed < limit;
  endfunction

  // Total edges from a clean supply rise until a hold releases.
  function automatic int unsigned release_edges(input int unsigned sync_depth,
                                                input int unsigned debounce,
                                                input int unsigned hold);
    return sync_depth + debounce + hold;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pwr_guard_sync.sv
module pwr_guard_sync #(
  parameter int unsigned SYNC_STAGES     = 2,
  parameter int unsigned DEBOUNCE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic sup_sync,
  output logic sup_trusted
);
  localparam int unsigned DB_W = $clog2(DEBOUNCE_CYCLES + 1);
  localparam logic [DB_W-1:0] DB_LAST = DB_W'(DEBOUNCE_CYCLES - 1);

  logic [SYNC_STAGES-1:0] chain;
  logic [DB_W-1:0]        stable_cnt;
  logic                   trusted_q;

  // Synchronizer chain; reset forces "supply bad".
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[SYNC_STAGES-2:0], raw_in};
  end

  assign sup_sync = chain[SYNC_STAGES-1];

  // A low sample distrusts at once; a high run must reach DEBOUNCE_CYCLES.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stable_cnt <= '0;
      trusted_q  <= 1'b0;
    end else if (!sup_sync) begin
      stable_cnt <= '0;
      trusted_q  <= 1'b0;
    end else if (!trusted_q) begin
      if (stable_cnt == DB_LAST) trusted_q <= 1'b1;
      else                       stable_cnt <= stable_cnt + 1'b1;
    end
  end

  assign sup_trusted = trusted_q;

  initial begin
    a_sync_depth_r2: assert (SYNC_STAGES >= 2)
      else $error("synchronizer needs at least two stages");
  end

  // R2: a bad synchronized sample removes trust on the next edge.
  p_fail_untrusts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_sync |=> !sup_trusted);

  // R5: trust only appears after a good synchronized sample.
  p_trust_needs_good_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sup_trusted) |-> $past(sup_sync));

endmodule

// File: rtl/pwr_guard_seq.sv
module pwr_guard_seq #(
  parameter int unsigned WP_HOLD_CYCLES  = 12_500_000,
  parameter int unsigned RST_HOLD_CYCLES = 35_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_sync,
  input  logic sup_trusted,
  output logic wp_hold,
  output logic rst_hold
);
  import pwr_guard_pkg::*;

  localparam int unsigned HOLD_MAX = max2(WP_HOLD_CYCLES, RST_HOLD_CYCLES);
  localparam int unsigned CNT_W    = $clog2(HOLD_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HOLD_MAX);

  logic [CNT_W-1:0] elapsed;

  // One elapsed-time counter from the moment of trust, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                elapsed <= '0;
    else if (!sup_trusted)     elapsed <= '0;
    else if (elapsed != CNT_TOP) elapsed <= elapsed + 1'b1;
  end

  // The raw synchronized level also gates, so a failure acts without waiting for trust to drop.
  assign wp_hold  = !sup_sync || !sup_trusted || hold_open(32'(elapsed), WP_HOLD_CYCLES);
  assign rst_hold = !sup_sync || !sup_trusted || hold_open(32'(elapsed), RST_HOLD_CYCLES);

  // R6: while trusted, the counter steps by one or sits at its top.
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_trusted && $past(sup_trusted)) |->
      (elapsed == $past(elapsed) + 1'b1 || elapsed == CNT_TOP));

  // R8: losing trust restarts the elapsed count.
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_trusted |=> elapsed == '0);

  generate
    if (WP_HOLD_CYCLES <= RST_HOLD_CYCLES) begin : g_order
      // R7: reset is never released while write protection still holds.
      p_rst_covers_wp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_hold |-> !wp_hold);
    end
  endgenerate

endmodule

// File: rtl/pwr_guard_gate.sv
module pwr_guard_gate #(
  parameter int unsigned N_STROBES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 protect,
  input  logic [N_STROBES-1:0] host_n,
  output logic [N_STROBES-1:0] gated_n
);
  // Each active-low strobe is forced inactive while protected, combinationally.
  for (genvar i = 0; i < N_STROBES; i++) begin : g_strobe
    assign gated_n[i] = host_n[i] | protect;
  end

  // R3: while protected, every memory strobe is inactive.
  p_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    protect |-> (&gated_n));

  // R9: without protection, strobes follow the host.
  p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !protect |-> (gated_n == host_n));

endmodule

// File: rtl/pwr_guard.sv
module pwr_guard #(
  parameter int unsigned SYNC_STAGES     = 2,
  parameter int unsigned DEBOUNCE_CYCLES = 16,
  parameter int unsigned WP_HOLD_CYCLES  = 12_500_000,
  parameter int unsigned RST_HOLD_CYCLES = 35_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_raw,
  input  logic host_ce_n,
  input  logic host_we_n,
  output logic mem_ce_n,
  output logic mem_we_n,
  output logic rst_pull_en,
  output logic wp_active
);
  logic       sup_sync;
  logic       sup_trusted;
  logic       wp_hold;
  logic       rst_hold;
  logic [1:0] gated_n;

  pwr_guard_sync #(
    .SYNC_STAGES    (SYNC_STAGES),
    .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
  ) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .raw_in     (supply_ok_raw),
    .sup_sync   (sup_sync),
    .sup_trusted(sup_trusted)
  );

  pwr_guard_seq #(
    .WP_HOLD_CYCLES (WP_HOLD_CYCLES),
    .RST_HOLD_CYCLES(RST_HOLD_CYCLES)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .sup_sync   (sup_sync),
    .sup_trusted(sup_trusted),
    .wp_hold    (wp_hold),
    .rst_hold   (rst_hold)
  );

  pwr_guard_gate #(
    .N_STROBES(2)
  ) u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .protect(wp_hold),
    .host_n ({host_we_n, host_ce_n}),
    .gated_n(gated_n)
  );

  assign mem_ce_n    = gated_n[0];
  assign mem_we_n    = gated_n[1];
  assign wp_active   = wp_hold;
  assign rst_pull_en = rst_hold;

  // R2/R4: a synchronized failure blocks a write and pulls reset in the same cycle.
  p_fail_cuts_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_sync |-> (mem_we_n && mem_ce_n && rst_pull_en));

  // R10: reset is pulled whenever the supply is not yet trusted.
  p_pull_untrusted_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_trusted |-> rst_pull_en);

endmodule

// File: tb/pwr_guard_bench.sv
module pwr_guard_bench;
  localparam int unsigned DEB = 4;
  localparam int unsigned WP  = 20;
  localparam int unsigned RST = 50;
  localparam int unsigned SYN = 2;
  // Release edges counted from a clean rise, restated from R6/R7.
  localparam int unsigned T_WP  = SYN + DEB + WP;
  localparam int unsigned T_RST = SYN + DEB + RST;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok_raw = 1'b1;
  logic host_ce_n = 1'b1;
  logic host_we_n = 1'b1;
  logic mem_ce_n, mem_we_n, rst_pull_en, wp_active;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwr_guard #(
    .SYNC_STAGES(SYN), .DEBOUNCE_CYCLES(DEB),
    .WP_HOLD_CYCLES(WP), .RST_HOLD_CYCLES(RST)
  ) u_pwr_guard (
    .clk(clk), .rst_n(rst_n), .supply_ok_raw(supply_ok_raw),
    .host_ce_n(host_ce_n), .host_we_n(host_we_n),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .rst_pull_en(rst_pull_en), .wp_active(wp_active)
  );

  // Sample 2 ns after the n-th rising edge.
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // Expected {mem_ce_n, mem_we_n, rst_pull_en, wp_active}.
  function automatic logic [3:0] expv(input logic rst_e, input logic wp_e);
    return wp_e ? {2'b11, rst_e, 1'b1} : {host_ce_n, host_we_n, rst_e, 1'b0};
  endfunction

  task automatic chk(input string req, input logic [3:0] exp_v);
    logic [3:0] act;
    act = {mem_ce_n, mem_we_n, rst_pull_en, wp_active};
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: {ce,we,rst,wp} actual %b expected %b at %0t", req, act, exp_v, $time);
    end
  endtask

  // Raise supply and check both release edges (R6, R7).
  task automatic rise_and_release(input string tag);
    @(negedge clk) supply_ok_raw = 1'b1;
    step(T_WP - 1);  chk({tag, " R6 wp still held"}, expv(1'b1, 1'b1));
    step(1);         chk({tag, " R6 wp released"},   expv(1'b1, 1'b0));
    step(T_RST - T_WP - 1); chk({tag, " R7 rst still held"}, expv(1'b1, 1'b0));
    step(1);         chk({tag, " R7/R10 rst released"}, expv(1'b0, 1'b0));
  endtask

  task automatic t_reset;
    rst_n = 1'b0; supply_ok_raw = 1'b1; host_ce_n = 1'b0; host_we_n = 1'b0;
    step(3);
    chk("R1 reset state", 4'b1111);
    @(negedge clk) host_ce_n = 1'b1; host_we_n = 1'b1;
  endtask

  task automatic t_powerup;
    // Release reset with supply good: behaves as a rise at this edge.
    @(negedge clk) rst_n = 1'b1;
    step(T_WP - 1);  chk("R6 power-up wp held", expv(1'b1, 1'b1));
    step(1);         chk("R6 power-up wp released", expv(1'b1, 1'b0));
    step(T_RST - T_WP - 1); chk("R7 power-up rst held", expv(1'b1, 1'b0));
    step(1);         chk("R7 power-up rst released", expv(1'b0, 1'b0));
  endtask

  task automatic t_passthru;
    @(negedge clk) host_ce_n = 1'b0; host_we_n = 1'b1; #1;
    chk("R9 ce only", {2'b01, 2'b00});
    @(negedge clk) host_we_n = 1'b0; #1;
    chk("R9 ce and we", {2'b00, 2'b00});
    @(negedge clk) host_ce_n = 1'b1; #1;
    chk("R9 we only", {2'b10, 2'b00});
  endtask

  task automatic t_fail_cut_write;
    @(negedge clk) host_ce_n = 1'b0; host_we_n = 1'b0; supply_ok_raw = 1'b0;
    step(1); chk("R2 not yet gated after one edge", {2'b00, 2'b00});
    step(1); chk("R2/R4 write cut off", 4'b1111);
  endtask

  task automatic t_ignore;
    @(negedge clk) host_ce_n = 1'b1; host_we_n = 1'b0; #1;
    chk("R3 we ignored", 4'b1111);
    @(negedge clk) host_ce_n = 1'b0; host_we_n = 1'b1; #1;
    chk("R3 ce ignored", 4'b1111);
    @(negedge clk) host_ce_n = 1'b1; host_we_n = 1'b1;
    step(3);
  endtask

  task automatic t_debounce;
    @(negedge clk) host_ce_n = 1'b0; host_we_n = 1'b0; supply_ok_raw = 1'b1;
    step(4);
    @(negedge clk) supply_ok_raw = 1'b0;
    step(T_WP - 6); chk("R5 glitch keeps protection", 4'b1111);
    @(negedge clk) supply_ok_raw = 1'b1;
    step(T_WP - 1); chk("R5 count restarted, still held", expv(1'b1, 1'b1));
    step(1);        chk("R5 release from last rise", expv(1'b1, 1'b0));
    step(T_RST - T_WP); chk("R5/R7 rst release from last rise", expv(1'b0, 1'b0));
  endtask

  task automatic t_drop_in_holds;
    @(negedge clk) host_ce_n = 1'b1; host_we_n = 1'b1; supply_ok_raw = 1'b0;
    step(4);
    // Drop inside the write-protect hold.
    @(negedge clk) supply_ok_raw = 1'b1;
    step(SYN + DEB + 5);
    chk("R8 inside wp hold", expv(1'b1, 1'b1));
    @(negedge clk) supply_ok_raw = 1'b0;
    step(3); chk("R8 drop in wp hold", 4'b1111);
    rise_and_release("R8 after wp-hold drop");
    // Drop after write protection ended but reset still held.
    @(negedge clk) supply_ok_raw = 1'b0;
    step(3);
    @(negedge clk) supply_ok_raw = 1'b1;
    step(T_WP + 5); chk("R8 in rst-only hold", expv(1'b1, 1'b0));
    @(negedge clk) supply_ok_raw = 1'b0;
    step(1); chk("R8 one edge after drop", expv(1'b1, 1'b0));
    step(1); chk("R8 drop in rst hold", 4'b1111);
    step(2);
    rise_and_release("R8 after rst-hold drop");
  endtask

  initial begin
    t_reset;
    t_powerup;
    t_passthru;
    t_fail_cut_write;
    t_ignore;
    t_debounce;
    t_drop_in_holds;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule